// File: doc/BRIEF.md
# Receive Alarm Status and Interrupt Register

This block sits between receive alarm detectors and a host register port. It shows the live red and yellow alarm levels, latches each alarm state transition into a sticky change bit, and raises one interrupt line when an enabled change bit is pending and the block-level enable is on.

The host reads and writes three 8-bit registers through a simple synchronous port. A status register holds the live state bits and the sticky change bits. An enable register holds one enable per change source. A control register holds the clear-policy select and the block-level interrupt enable. Change bits are cleared in one of two ways. In write-one-to-clear mode, each one written to a change bit clears it. In reset-upon-read mode, a host read of the status register returns the latched bits and clears them on the following cycle.

Top module: `alarm_irq_regs`

## Requirements
- R1: Status bit 7 always reads the current red alarm level input, and status bit 6 always reads the current yellow alarm level input. Host writes never affect these bits.
- R2: A change pulse on the red or yellow input sets its sticky bit (status bit 2 for red, bit 1 for yellow) at the next clock edge. The bit stays set until it is cleared as described in R3 or R4.
- R3: When control bit 0 is zero (write-one-to-clear mode), a write to the status register (address 0) clears each change bit whose data bit is one and leaves the others unchanged. A read does not clear anything in this mode.
- R4: When control bit 0 is one (reset-upon-read mode), a read of the status register returns the latched change bits in the cycle of the read, and those bits read zero from the next cycle. Writes to the status register have no effect in this mode.
- R5: If a change pulse arrives in the same cycle as a clear of its bit, the bit remains set.
- R6: The irq output is high exactly when control bit 1 (block enable) is one and at least one change bit is set whose per-source enable is one. The per-source enables sit in the enable register (address 1): bit 2 for red and bit 1 for yellow.
- R7: irq falls in the cycle after the last enabled pending change bit is cleared.
- R8: After reset, all change bits, the enable register, the control register and irq are zero.
- R9: The enable register (address 1) and the control register (address 2) read back what was written in their defined bits. All undefined bits read zero, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| red_state_i | input | 1 | Live red alarm level |
| red_chg_i | input | 1 | One-cycle pulse on a red alarm state transition |
| yel_state_i | input | 1 | Live yellow alarm level |
| yel_chg_i | input | 1 | One-cycle pulse on a yellow alarm state transition |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (it matters only for reset-upon-read) |
| rd_data | output | 8 | Combinational read data for addr |
| irq | output | 1 | Aggregate alarm interrupt |

## Verification
The assertions assume that change pulses last one cycle, that the detectors drive them in step with the level inputs, and that the host never asserts read and write in the same cycle. The directed tasks drive every input on the falling clock edge, give each pulse exactly one cycle, and issue one host access at a time. The collision cases depend on a pulse and a clear coinciding, so they are driven deliberately on the same edge.

// File: rtl/alarm_irq_regs.sv
module alarm_irq_regs #(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 0,
  parameter logic [ADDR_W-1:0] IEN_ADDR  = 1,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              red_state_i,
  input  logic              red_chg_i,
  input  logic              yel_state_i,
  input  logic              yel_chg_i,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic              irq
);
  localparam int B_RST = 7;
  localparam int B_YST = 6;
  localparam int B_RCH = 2;
  localparam int B_YCH = 1;
  localparam int B_RUR = 0;
  localparam int B_BEN = 1;

  logic chg_red, chg_yel, en_red, en_yel, rur, blk_en;

  wire stat_sel = (addr == STAT_ADDR);
  wire w1c      = wr_en && stat_sel && !rur;
  wire rd_clr   = rd_en && stat_sel && rur;
  wire clr_red  = (w1c && wr_data[B_RCH]) || rd_clr;
  wire clr_yel  = (w1c && wr_data[B_YCH]) || rd_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_red <= 1'b0;
      chg_yel <= 1'b0;
      en_red  <= 1'b0;
      en_yel  <= 1'b0;
      rur     <= 1'b0;
      blk_en  <= 1'b0;
    end else begin
      chg_red <= (chg_red && !clr_red) || red_chg_i;
      chg_yel <= (chg_yel && !clr_yel) || yel_chg_i;
      if (wr_en && addr == IEN_ADDR) begin
        en_red <= wr_data[B_RCH];
        en_yel <= wr_data[B_YCH];
      end
      if (wr_en && addr == CTRL_ADDR) begin
        rur    <= wr_data[B_RUR];
        blk_en <= wr_data[B_BEN];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == STAT_ADDR) begin
      rd_data[B_RST] = red_state_i;
      rd_data[B_YST] = yel_state_i;
      rd_data[B_RCH] = chg_red;
      rd_data[B_YCH] = chg_yel;
    end else if (addr == IEN_ADDR) begin
      rd_data[B_RCH] = en_red;
      rd_data[B_YCH] = en_yel;
    end else if (addr == CTRL_ADDR) begin
      rd_data[B_RUR] = rur;
      rd_data[B_BEN] = blk_en;
    end
  end

  assign irq = blk_en && ((chg_red && en_red) || (chg_yel && en_yel));
endmodule

module alarm_irq_regs_chk #(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              red_state_i,
  input logic              red_chg_i,
  input logic              yel_state_i,
  input logic              yel_chg_i,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic              irq,
  input logic              chg_red,
  input logic              chg_yel,
  input logic              en_red,
  input logic              en_yel,
  input logic              rur,
  input logic              blk_en
);
  a_r1_live_state: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == STAT_ADDR) |-> (rd_data[7] == red_state_i && rd_data[6] == yel_state_i));
  a_r2_red_capture: assert property (@(posedge clk) disable iff (!rst_n)
    red_chg_i |=> chg_red);
  a_r2_yel_capture: assert property (@(posedge clk) disable iff (!rst_n)
    yel_chg_i |=> chg_yel);
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == STAT_ADDR && rur && !red_chg_i && !yel_chg_i)
      |=> (!chg_red && !chg_yel));
  a_r4_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && addr == STAT_ADDR && rur && chg_red) |=> chg_red);
  a_r6_block_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_en |-> !irq);
  a_r6_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((chg_red && en_red) || (chg_yel && en_yel)));
endmodule

bind alarm_irq_regs alarm_irq_regs_chk #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .red_state_i(red_state_i), .red_chg_i(red_chg_i),
  .yel_state_i(yel_state_i), .yel_chg_i(yel_chg_i), .addr(addr), .wr_en(wr_en),
  .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq),
  .chg_red(chg_red), .chg_yel(chg_yel), .en_red(en_red), .en_yel(en_yel),
  .rur(rur), .blk_en(blk_en));

// File: tb/alarm_irq_regs_test.sv
module alarm_irq_regs_test;
  logic clk = 0, rst_n = 0;
  logic red_state_i = 0, red_chg_i = 0, yel_state_i = 0, yel_chg_i = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  alarm_irq_regs uut (.clk(clk), .rst_n(rst_n), .red_state_i(red_state_i),
    .red_chg_i(red_chg_i), .yel_state_i(yel_state_i), .yel_chg_i(yel_chg_i),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .irq(irq));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0; wr_data = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse(logic red, logic yel);
    @(negedge clk); red_chg_i = red; yel_chg_i = yel;
    @(negedge clk); red_chg_i = 0; yel_chg_i = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d); chk("R8 status", d, 8'h00);
    rd(1, d); chk("R8 enables", d, 8'h00);
    rd(2, d); chk("R8 control", d, 8'h00);
    chk("R8 irq", irq, 0);
  endtask

  task automatic t_live();
    logic [7:0] d;
    red_state_i = 1; rd(0, d); chk("R1 red level", d, 8'h80);
    yel_state_i = 1; rd(0, d); chk("R1 both levels", d, 8'hC0);
    wr(0, 8'hFF); rd(0, d); chk("R1 write ignored", d, 8'hC0);
    red_state_i = 0; yel_state_i = 0; rd(0, d); chk("R1 levels low", d, 8'h00);
  endtask

  task automatic t_sticky_w1c();
    logic [7:0] d;
    pulse(1, 0); rd(0, d); chk("R2 red sticky", d, 8'h04);
    rd(0, d); chk("R3 read no clear", d, 8'h04);
    pulse(0, 1); rd(0, d); chk("R2 yel sticky", d, 8'h06);
    wr(0, 8'h02); rd(0, d); chk("R3 clear yel only", d, 8'h04);
    wr(0, 8'h00); rd(0, d); chk("R3 zero write keeps", d, 8'h04);
    wr(0, 8'h04); rd(0, d); chk("R3 clear red", d, 8'h00);
  endtask

  task automatic t_rur();
    logic [7:0] d;
    wr(2, 8'h01);
    pulse(1, 1);
    wr(0, 8'hFF); rd(1, d);
    addr = 0; #1 chk("R4 write ignored", rd_data, 8'h06);
    rd(0, d); chk("R4 read returns latched", d, 8'h06);
    rd(0, d); chk("R4 cleared after read", d, 8'h00);
    wr(2, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    pulse(1, 0);
    @(negedge clk); addr = 0; wr_data = 8'h04; wr_en = 1; red_chg_i = 1;
    @(negedge clk); wr_en = 0; wr_data = 0; red_chg_i = 0;
    rd(0, d); chk("R5 w1c collision", d, 8'h04);
    wr(0, 8'h04);
    wr(2, 8'h01);
    pulse(0, 1);
    @(negedge clk); addr = 0; rd_en = 1; yel_chg_i = 1;
    @(negedge clk); rd_en = 0; yel_chg_i = 0;
    #1 chk("R5 read collision", rd_data, 8'h02);
    rd(0, d); wr(2, 8'h00);
    rd(0, d); chk("R5 tidy", d, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(1, 8'h04); pulse(1, 0);
    chk("R6 no block enable", irq, 0);
    wr(2, 8'h02); chk("R6 enabled red", irq, 1);
    wr(1, 8'h02); chk("R6 red masked", irq, 0);
    pulse(0, 1); chk("R6 yel pending", irq, 1);
    wr(0, 8'h02); chk("R7 irq drops", irq, 0);
    rd(1, d); chk("R9 enables readback", d, 8'h02);
    rd(2, d); chk("R9 control readback", d, 8'h02);
    wr(1, 8'hFF); rd(1, d); chk("R9 undefined bits", d, 8'h06);
    chk("R6 red now unmasked", irq, 1);
    wr(0, 8'h04); chk("R7 irq drops red", irq, 0);
    rd(3, d); chk("R9 unmapped", d, 8'h00);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_live();
    t_sticky_w1c();
    t_rur();
    t_collide();
    t_irq();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule